// File: doc/BRIEF.md
# Interrupt Acknowledge and Nested Completion Unit

This unit serves one processor's view of a priority interrupt controller. An acknowledge request takes the highest-pending interrupt ID offered by the external selector and accepts it only if it beats the priority currently running. An accepted ID becomes the running interrupt. The ID it preempts is saved in a per-ID link table, and the pending bit of the accepted source is cleared. A completion (end-of-interrupt) request retires an interrupt and restores the one it preempted.

Active interrupts therefore form a singly linked preemption chain, headed by the running ID and ending in the idle code 1023. Completing the running ID pops the chain. Completing an ID buried in the chain unlinks it: a small walker follows the links, one per clock, patches the entry that points at it, and leaves the running ID and running priority alone. While the walker is busy, all new requests are dropped, so the bus side must wait for `busy` to fall.

In legacy mode, completing a level-sensitive source whose line is still high, and which is enabled and aimed at this processor, requests that its pending bit be set again.

Top module: `irq_ack_eoi_unit`

## Requirements
- R1: An acknowledge is refused when the offered ID is not below NUM_SRC (this includes 1023) or when its priority is not strictly smaller than the running priority. A refused acknowledge responds with ID 1023 and leaves the running ID, running priority and pending-clear output unchanged.
- R2: An accepted acknowledge responds with the offered ID one cycle after the request. In that same cycle the ID becomes running, its link entry holds the previously running ID, and bit ID of `pend_clr` is the only bit set for that one cycle.
- R3: `run_prio` is the 9-bit zero-extended priority of the running ID, taken when that ID became running, and it is 256 (0x100) whenever `run_id` is 1023.
- R4: A completion uses only bits 9:0 of `eoi_wdata` as the ID. IDs at or above NUM_SRC, including 1023, are ignored.
- R5: A completion arriving while `run_id` is 1023 is ignored.
- R6: Completing the running ID makes its link entry the new running ID, with the priority taken again from that ID.
- R7: Completing a non-running ID in the chain rewrites the link of the entry that points at it with the completed ID's own link. The running ID and running priority are not changed, and a later completion of the remaining IDs follows the patched chain.
- R8: The chain walk takes one clock per link visited and stops at a link of 1023 (so a valid ID absent from the chain changes nothing). `busy` is high for exactly those clocks, and acknowledge and completion requests arriving while `busy` is high are dropped with no response.
- R9: In legacy mode, an accepted completion of ID n sets bit n of `pend_set` for one cycle, one cycle later, when source n is level-sensitive (`src_edge[n]`=0), enabled, its line is high and it targets this processor. Otherwise `pend_set` stays zero.
- R10: When an acknowledge and a completion arrive in the same cycle, the acknowledge is served and the completion is dropped.
- R11: After reset, `run_id` is 1023, `run_prio` is 256, every link entry is 1023, and `busy`, `ack_rsp_valid`, `pend_clr` and `pend_set` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ack_req | input | 1 | Acknowledge request strobe |
| hp_id | input | 10 | Highest-pending ID from the selector |
| eoi_req | input | 1 | Completion request strobe |
| eoi_wdata | input | 32 | Completion write value; bits 9:0 are the ID |
| src_prio | input | NUM_SRC*PRIO_W | Priority of each source, source n at bits n*PRIO_W upward |
| legacy_en | input | 1 | Enables the level re-pend rule on completion |
| src_edge | input | NUM_SRC | 1 = edge-sensitive source, 0 = level-sensitive |
| src_enable | input | NUM_SRC | Source enabled |
| src_line | input | NUM_SRC | Current input line level of each source |
| src_to_me | input | NUM_SRC | Source targets this processor |
| ack_rsp_valid | output | 1 | Acknowledge response valid |
| ack_rsp_id | output | 10 | Acknowledged ID, or 1023 |
| pend_clr | output | NUM_SRC | One-cycle pending-clear pulse, bit = ID |
| pend_set | output | NUM_SRC | One-cycle pending-set pulse, bit = ID |
| run_id | output | 10 | Running interrupt ID, 1023 when idle |
| run_prio | output | PRIO_W+1 | Running priority, 256 when idle |
| busy | output | 1 | Chain walk in progress; requests dropped |

## Verification
The bench builds a three-deep preemption chain and completes an interrupt from its middle. A design that forgot to patch the link would later resume an interrupt that was already finished. It also completes a valid ID that is absent from the chain, where a walker without the 1023 stop would spin or corrupt a link, and it fires an acknowledge during the walk to catch a unit that lets requests slip through while busy. It further probes equal priority (a non-strict compare would accept), out-of-range and masked-high completion IDs, simultaneous acknowledge and completion, and a completion while idle. Finally it exercises the level re-pend rule with the line high, with an edge-sensitive source, and with legacy mode off.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int ID_W = 10;
  localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;

  typedef enum logic {
    WALK_IDLE = 1'b0,
    WALK_RUN  = 1'b1
  } walk_state_e;
endpackage

// File: rtl/irq_ack_link_table.sv
module irq_ack_link_table
  import irq_ack_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int N_RD    = 3
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic [ID_W-1:0]           wr_idx,
  input  logic [ID_W-1:0]           wr_data,
  input  logic [N_RD-1:0][ID_W-1:0] rd_idx,
  output logic [N_RD-1:0][ID_W-1:0] rd_data
);
  logic [ID_W-1:0] link_q [NUM_SRC];

  // One register per source; an entry holds the ID it preempted.
  for (genvar e = 0; e < NUM_SRC; e++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == ID_W'(e));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        link_q[e] <= NO_IRQ;
      end else if (hit) begin
        link_q[e] <= wr_data;
      end
    end
  end

  // Out-of-range read index yields the idle code.
  always_comb begin
    for (int r = 0; r < N_RD; r++) begin
      rd_data[r] = NO_IRQ;
      for (int e = 0; e < NUM_SRC; e++) begin
        if (rd_idx[r] == ID_W'(e)) rd_data[r] = link_q[e];
      end
    end
  end

  a_r2_link_write_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < ID_W'(NUM_SRC)));
endmodule

// File: rtl/irq_ack_chain_walker.sv
module irq_ack_chain_walker
  import irq_ack_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [ID_W-1:0] start_cursor,
  input  logic [ID_W-1:0] start_target,
  input  logic [ID_W-1:0] cur_link,
  input  logic [ID_W-1:0] tgt_link,
  output logic [ID_W-1:0] cursor,
  output logic [ID_W-1:0] target,
  output logic            busy,
  output logic            wr_en,
  output logic [ID_W-1:0] wr_idx,
  output logic [ID_W-1:0] wr_data
);
  walk_state_e     state_q, state_d;
  logic [ID_W-1:0] cursor_q, cursor_d;
  logic [ID_W-1:0] target_q, target_d;
  logic            cursor_en;

  always_comb begin
    state_d   = state_q;
    cursor_d  = cursor_q;
    target_d  = target_q;
    cursor_en = 1'b0;
    wr_en     = 1'b0;
    wr_idx    = cursor_q;
    wr_data   = tgt_link;
    case (state_q)
      WALK_IDLE: begin
        if (start) begin
          state_d   = WALK_RUN;
          cursor_d  = start_cursor;
          target_d  = start_target;
          cursor_en = 1'b1;
        end
      end
      WALK_RUN: begin
        if (cur_link == NO_IRQ) begin
          state_d = WALK_IDLE;
        end else if (cur_link == target_q) begin
          wr_en   = 1'b1;
          state_d = WALK_IDLE;
        end else begin
          cursor_d  = cur_link;
          cursor_en = 1'b1;
        end
      end
      default: state_d = WALK_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= WALK_IDLE;
      cursor_q <= NO_IRQ;
      target_q <= NO_IRQ;
    end else begin
      state_q <= state_d;
      if (cursor_en) begin
        cursor_q <= cursor_d;
        target_q <= target_d;
      end
    end
  end

  assign busy   = (state_q == WALK_RUN);
  assign cursor = cursor_q;
  assign target = target_q;

  a_r8_start_only_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start |-> !busy);
  a_r8_walk_never_patches_self: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx != target_q));
endmodule

// File: rtl/irq_ack_repend.sv
module irq_ack_repend
  import irq_ack_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               fire,
  input  logic               legacy_en,
  input  logic [ID_W-1:0]    id,
  input  logic [NUM_SRC-1:0] src_edge,
  input  logic [NUM_SRC-1:0] src_enable,
  input  logic [NUM_SRC-1:0] src_line,
  input  logic [NUM_SRC-1:0] src_to_me,
  output logic [NUM_SRC-1:0] set_vec
);
  logic armed;
  assign armed = fire && legacy_en;

  for (genvar e = 0; e < NUM_SRC; e++) begin : g_src
    assign set_vec[e] = armed && (id == ID_W'(e)) && !src_edge[e] &&
                        src_enable[e] && src_line[e] && src_to_me[e];
  end
endmodule

// File: rtl/irq_ack_eoi_unit.sv
module irq_ack_eoi_unit
  import irq_ack_pkg::*;
#(
  parameter int NUM_SRC = 32,
  parameter int PRIO_W  = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      ack_req,
  input  logic [ID_W-1:0]           hp_id,
  input  logic                      eoi_req,
  input  logic [31:0]               eoi_wdata,
  input  logic [NUM_SRC*PRIO_W-1:0] src_prio,
  input  logic                      legacy_en,
  input  logic [NUM_SRC-1:0]        src_edge,
  input  logic [NUM_SRC-1:0]        src_enable,
  input  logic [NUM_SRC-1:0]        src_line,
  input  logic [NUM_SRC-1:0]        src_to_me,
  output logic                      ack_rsp_valid,
  output logic [ID_W-1:0]           ack_rsp_id,
  output logic [NUM_SRC-1:0]        pend_clr,
  output logic [NUM_SRC-1:0]        pend_set,
  output logic [ID_W-1:0]           run_id,
  output logic [PRIO_W:0]           run_prio,
  output logic                      busy
);
  localparam logic [PRIO_W:0] IDLE_PRIO = (PRIO_W+1)'(1) << PRIO_W;
  localparam int              N_RD      = 3;

  function automatic logic [PRIO_W:0] prio_of(input logic [ID_W-1:0] id,
                                              input logic [NUM_SRC*PRIO_W-1:0] tbl);
    prio_of = IDLE_PRIO;
    for (int e = 0; e < NUM_SRC; e++) begin
      if (id == ID_W'(e)) prio_of = {1'b0, tbl[e*PRIO_W +: PRIO_W]};
    end
  endfunction

  logic [ID_W-1:0]    run_id_q, run_id_d;
  logic [PRIO_W:0]    run_prio_q, run_prio_d;
  logic               run_en;
  logic               rsp_v_q, rsp_v_d;
  logic [ID_W-1:0]    rsp_id_q, rsp_id_d;
  logic [NUM_SRC-1:0] clr_q, clr_d, set_q, set_d;

  logic [ID_W-1:0]    eoi_id;
  logic               unused_eoi_hi;
  logic [PRIO_W:0]    hp_prio, restore_prio;
  logic               ack_take, ack_ok, eoi_take, eoi_run, eoi_walk;

  logic [N_RD-1:0][ID_W-1:0] rd_idx, rd_data;
  logic [ID_W-1:0]    restore_id;
  logic               tbl_wr_en;
  logic [ID_W-1:0]    tbl_wr_idx, tbl_wr_data;
  logic               walk_wr_en;
  logic [ID_W-1:0]    walk_wr_idx, walk_wr_data, walk_cursor, walk_target;

  assign eoi_id        = eoi_wdata[ID_W-1:0];
  assign unused_eoi_hi = ^eoi_wdata[31:ID_W];

  // Request qualification: busy blocks both, acknowledge beats completion.
  assign hp_prio  = prio_of(hp_id, src_prio);
  assign ack_take = ack_req && !busy;
  assign ack_ok   = ack_take && (hp_id < ID_W'(NUM_SRC)) && (hp_prio < run_prio_q);
  assign eoi_take = eoi_req && !busy && !ack_req &&
                    (eoi_id < ID_W'(NUM_SRC)) && (run_id_q != NO_IRQ);
  assign eoi_run  = eoi_take && (eoi_id == run_id_q);
  assign eoi_walk = eoi_take && !eoi_run;

  assign rd_idx       = {walk_target, walk_cursor, run_id_q};
  assign restore_id   = rd_data[0];
  assign restore_prio = prio_of(restore_id, src_prio);

  irq_ack_link_table #(.NUM_SRC(NUM_SRC), .N_RD(N_RD)) u_links (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (tbl_wr_en),
    .wr_idx  (tbl_wr_idx),
    .wr_data (tbl_wr_data),
    .rd_idx  (rd_idx),
    .rd_data (rd_data)
  );

  irq_ack_chain_walker u_walker (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (eoi_walk),
    .start_cursor (run_id_q),
    .start_target (eoi_id),
    .cur_link     (rd_data[1]),
    .tgt_link     (rd_data[2]),
    .cursor       (walk_cursor),
    .target       (walk_target),
    .busy         (busy),
    .wr_en        (walk_wr_en),
    .wr_idx       (walk_wr_idx),
    .wr_data      (walk_wr_data)
  );

  irq_ack_repend #(.NUM_SRC(NUM_SRC)) u_repend (
    .fire       (eoi_take),
    .legacy_en  (legacy_en),
    .id         (eoi_id),
    .src_edge   (src_edge),
    .src_enable (src_enable),
    .src_line   (src_line),
    .src_to_me  (src_to_me),
    .set_vec    (set_d)
  );

  // Link write port: acknowledge and walk are mutually exclusive via busy.
  always_comb begin
    if (ack_ok) begin
      tbl_wr_en   = 1'b1;
      tbl_wr_idx  = hp_id;
      tbl_wr_data = run_id_q;
    end else begin
      tbl_wr_en   = walk_wr_en;
      tbl_wr_idx  = walk_wr_idx;
      tbl_wr_data = walk_wr_data;
    end
  end

  always_comb begin
    run_en     = 1'b0;
    run_id_d   = run_id_q;
    run_prio_d = run_prio_q;
    if (ack_ok) begin
      run_en     = 1'b1;
      run_id_d   = hp_id;
      run_prio_d = hp_prio;
    end else if (eoi_run) begin
      run_en     = 1'b1;
      run_id_d   = restore_id;
      run_prio_d = restore_prio;
    end
  end

  always_comb begin
    rsp_v_d  = ack_take;
    rsp_id_d = ack_ok ? hp_id : NO_IRQ;
    clr_d    = '0;
    for (int e = 0; e < NUM_SRC; e++) begin
      if (ack_ok && (hp_id == ID_W'(e))) clr_d[e] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_id_q   <= NO_IRQ;
      run_prio_q <= IDLE_PRIO;
      rsp_v_q    <= 1'b0;
      rsp_id_q   <= NO_IRQ;
      clr_q      <= '0;
      set_q      <= '0;
    end else begin
      if (run_en) begin
        run_id_q   <= run_id_d;
        run_prio_q <= run_prio_d;
      end
      rsp_v_q  <= rsp_v_d;
      rsp_id_q <= rsp_id_d;
      clr_q    <= clr_d;
      set_q    <= set_d;
    end
  end

  assign run_id        = run_id_q;
  assign run_prio      = run_prio_q;
  assign ack_rsp_valid = rsp_v_q;
  assign ack_rsp_id    = rsp_id_q;
  assign pend_clr      = clr_q;
  assign pend_set      = set_q;

  a_r3_idle_prio: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id_q == NO_IRQ) |-> (run_prio_q == IDLE_PRIO));
  a_r3_active_prio_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (run_id_q != NO_IRQ) |-> !run_prio_q[PRIO_W]);
  a_r2_granted_is_running: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_v_q && rsp_id_q != NO_IRQ) |-> (run_id_q == rsp_id_q));
  a_r1_refusal_keeps_running: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_v_q && rsp_id_q == NO_IRQ) |-> ($stable(run_id_q) && clr_q == '0));
  a_r8_busy_freezes_running: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (run_id_q == $past(run_id_q)));
  a_r2_clear_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(clr_q));
  a_r9_set_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(set_q));
endmodule

// File: tb/irq_ack_eoi_unit_tb.sv
module irq_ack_eoi_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 32;
  localparam int PW = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic ack_req, eoi_req, legacy_en;
  logic [9:0] hp_id;
  logic [31:0] eoi_wdata;
  logic [NS*PW-1:0] src_prio;
  logic [NS-1:0] src_edge, src_enable, src_line, src_to_me;
  logic ack_rsp_valid, busy;
  logic [9:0] ack_rsp_id, run_id;
  logic [NS-1:0] pend_clr, pend_set;
  logic [PW:0] run_prio;

  logic [7:0] prio_m [NS];
  int m_run, m_prio, m_busy;
  int m_link [NS];
  int e_rsp_v, e_rsp_id;
  longint e_clr, e_set;
  int checks = 0, fails = 0;
  string cur_req = "R11";

  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    for (int e = 0; e < NS; e++) src_prio[e*PW +: PW] = prio_m[e];
  end

  irq_ack_eoi_unit #(.NUM_SRC(NS), .PRIO_W(PW)) u_dut (
    .clk(clk), .rst_n(rst_n), .ack_req(ack_req), .hp_id(hp_id),
    .eoi_req(eoi_req), .eoi_wdata(eoi_wdata), .src_prio(src_prio),
    .legacy_en(legacy_en), .src_edge(src_edge), .src_enable(src_enable),
    .src_line(src_line), .src_to_me(src_to_me), .ack_rsp_valid(ack_rsp_valid),
    .ack_rsp_id(ack_rsp_id), .pend_clr(pend_clr), .pend_set(pend_set),
    .run_id(run_id), .run_prio(run_prio), .busy(busy)
  );

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  task automatic chk(string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", cur_req, what, act, exp);
    end
  endtask

  // Behavioural reference: one call per clock edge, using pre-edge inputs.
  task automatic model_step();
    int id, cur, lk, k;
    e_rsp_v = 0; e_rsp_id = 1023; e_clr = 0; e_set = 0;
    if (m_busy > 0) begin
      m_busy--;
    end else if (ack_req) begin
      e_rsp_v = 1;
      id = int'(hp_id);
      if (id < NS && int'(prio_m[id]) < m_prio) begin
        m_link[id] = m_run; m_run = id; m_prio = int'(prio_m[id]);
        e_rsp_id = id; e_clr = longint'(1) << id;
      end
    end else if (eoi_req) begin
      id = int'(eoi_wdata & 32'h3ff);
      if (id < NS && m_run != 1023) begin
        if (legacy_en && !src_edge[id] && src_enable[id] && src_line[id] && src_to_me[id])
          e_set = longint'(1) << id;
        if (id == m_run) begin
          m_run  = m_link[id];
          m_prio = (m_run == 1023) ? 256 : int'(prio_m[m_run]);
        end else begin
          cur = m_run; k = 0;
          while (1) begin
            k++;
            lk = m_link[cur];
            if (lk == 1023) break;
            if (lk == id) begin m_link[cur] = m_link[id]; break; end
            cur = lk;
          end
          m_busy = k;
        end
      end
    end
  endtask

  task automatic compare();
    chk("run_id", run_id, m_run);
    chk("run_prio", run_prio, m_prio);
    chk("busy", busy, (m_busy > 0));
    chk("ack_rsp_valid", ack_rsp_valid, e_rsp_v);
    if (e_rsp_v != 0) chk("ack_rsp_id", ack_rsp_id, e_rsp_id);
    chk("pend_clr", pend_clr, e_clr);
    chk("pend_set", pend_set, e_set);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    compare();
    ack_req = 1'b0; eoi_req = 1'b0;
  endtask

  task automatic do_ack(int id);
    ack_req = 1'b1; hp_id = 10'(id); tick();
  endtask

  task automatic do_eoi(logic [31:0] v);
    eoi_req = 1'b1; eoi_wdata = v; tick();
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    report();
    $finish;
  end

  initial begin
    rst_n = 1'b0; ack_req = 1'b0; eoi_req = 1'b0; legacy_en = 1'b0;
    hp_id = 10'd1023; eoi_wdata = '0;
    src_edge = '0; src_enable = '0; src_line = '0; src_to_me = '0;
    for (int e = 0; e < NS; e++) begin prio_m[e] = 8'hC0; m_link[e] = 1023; end
    prio_m[1] = 8'h00; prio_m[3] = 8'h80; prio_m[5] = 8'h40; prio_m[7] = 8'h40;
    prio_m[12] = 8'h20; prio_m[20] = 8'h10; prio_m[31] = 8'hF0;
    m_run = 1023; m_prio = 256; m_busy = 0;
    e_rsp_v = 0; e_rsp_id = 1023; e_clr = 0; e_set = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R11"; compare();

    cur_req = "R1"; do_ack(1023); do_ack(40);
    cur_req = "R2"; do_ack(3);
    cur_req = "R1"; do_ack(31);
    cur_req = "R2"; do_ack(7);
    cur_req = "R1"; do_ack(5);
    cur_req = "R3"; do_ack(12); do_ack(20);
    cur_req = "R10"; ack_req = 1'b1; hp_id = 10'd1023; eoi_req = 1'b1; eoi_wdata = 32'd20; tick();
    cur_req = "R4"; do_eoi(32'd40); do_eoi(32'd1023);
    cur_req = "R7"; do_eoi(32'd7);
    cur_req = "R8"; do_ack(1); idle(2);
    cur_req = "R8"; do_eoi(32'd9); idle(4);
    cur_req = "R4"; do_eoi(32'hFFFF_FC14);
    cur_req = "R6"; do_eoi(32'd12);
    cur_req = "R9";
    legacy_en = 1'b1; src_enable[3] = 1'b1; src_line[3] = 1'b1; src_to_me[3] = 1'b1;
    do_eoi(32'd3);
    do_ack(3); src_edge[3] = 1'b1; do_eoi(32'd3);
    do_ack(3); src_edge[3] = 1'b0; legacy_en = 1'b0; do_eoi(32'd3);
    cur_req = "R5"; legacy_en = 1'b1; do_eoi(32'd3); idle(2);

    report();
    $finish;
  end
endmodule